// File: doc/BRIEF.md
# Twin-Precision Signed Booth Multiplier

This block multiplies two's-complement operands on one radix-4 Booth partial-product array. It has two modes. In full mode it forms one WIDTH-by-WIDTH signed product. In twin mode the same array forms two independent half-width signed products in the same pass, so each pass delivers twice as many results.

Each operand word is split into a lower half and an upper half. In twin mode the two lower halves form one product and the two upper halves form the other. Each half product is packed into its own WIDTH-bit field of the result word.

Booth rows are shared between the modes. The only mode-dependent logic is a little gating:
- the recoding boundary at the middle of the multiplier;
- the choice of multiplicand half for each row;
- the placement of each row in the result word;
- the single carry path between the two result fields.

An optional output register, chosen by parameter, captures a result only when the input is marked valid.

Top module: `twin_booth_mul`

## Requirements
- R1: With twinMode=0, result equals the signed product of opA and opB as a 2*WIDTH-bit two's-complement value.
- R2: With twinMode=1, result[WIDTH-1:0] equals the signed product of opA[WIDTH/2-1:0] and opB[WIDTH/2-1:0] as a WIDTH-bit two's-complement value.
- R3: With twinMode=1, result[2*WIDTH-1:WIDTH] equals the signed product of opA[WIDTH-1:WIDTH/2] and opB[WIDTH-1:WIDTH/2] as a WIDTH-bit two's-complement value.
- R4: In twin mode each result field depends only on its own operand halves. Changing the upper halves leaves result[WIDTH-1:0] unchanged, and neither a carry nor a sign extension crosses between the fields.
- R5: With REG_OUT=1, outValid rises in the cycle after an edge that samples inValid=1, falls in the cycle after an edge that samples inValid=0, and result then shows the product of the operands sampled at that edge.
- R6: With REG_OUT=1, an edge that samples inValid=0 leaves result unchanged, whatever the operands and mode.
- R7: While rstN is low, outValid is 0 and the registered result is 0.
- R8: The extreme operand values give exact products in both modes: the most negative value, -1, 0 and the largest positive value, in each half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operands and mode are valid this cycle |
| twinMode | input | 1 | 0: one full product; 1: two packed half products |
| opA | input | WIDTH | Multiplicand (upper and lower halves in twin mode) |
| opB | input | WIDTH | Multiplier (upper and lower halves in twin mode) |
| outValid | output | 1 | Result word is valid |
| result | output | 2*WIDTH | Full product, or {upper product, lower product} |

## Verification
The bench sweeps every operand pair of an 8-bit instance in both modes, then repeats the signed extremes on their own. The riskiest boundary is the middle Booth row. If the upper-half recoding borrowed the top bit of the lower multiplier half, twin results would be wrong whenever opB[3] is set, while full-mode results would stay correct. If the inter-field carry were left open in twin mode, the upper field would gain a stray carry from the lower sum. If that carry were closed in full mode, the upper half of nearly every full product would be wrong. Captures with inValid low show whether the register loads when it should hold.

// File: rtl/twin_booth_pkg.sv
package twin_booth_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic twin;   // select twin half-width products
    logic load;   // capture this pass into the output register
  } mulCtrl_t;

  // One radix-4 Booth digit: value is (neg ? -1 : 1) * (two ? 2 : one ? 1 : 0)
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } boothDigit_t;

  function automatic boothDigit_t boothEncode(input logic [2:0] tri3);
    boothDigit_t d;
    d.one = tri3[1] ^ tri3[0];
    d.two = (tri3[2] & ~tri3[1] & ~tri3[0]) | (~tri3[2] & tri3[1] & tri3[0]);
    d.neg = tri3[2] & ~(tri3[1] & tri3[0]);
    return d;
  endfunction

endpackage

// File: rtl/twin_booth_ctrl.sv
module twin_booth_ctrl
  import twin_booth_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     twinMode,
  output mulCtrl_t ctrl,
  output logic     outValid
);

  assign ctrl.twin = twinMode;
  assign ctrl.load = inValid;

  generate
    if (REG_OUT) begin : gRegValid
      logic validQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= inValid;
      end
      assign outValid = validQ;
    end else begin : gCombValid
      assign outValid = inValid;
    end
  endgenerate

endmodule

// File: rtl/twin_booth_dp.sv
module twin_booth_dp
  import twin_booth_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  mulCtrl_t           ctrl,
  output logic [2*WIDTH-1:0] product
);

  localparam int HALF  = WIDTH / 2;
  localparam int ROWS  = WIDTH / 2;
  localparam int QROWS = ROWS / 2;
  localparam int DW    = 2 * WIDTH;
  localparam int CW    = $clog2(ROWS) + 1;

  logic [DW-1:0] rowPp [ROWS];

  generate
    for (genvar r = 0; r < ROWS; r++) begin : gRow
      localparam int FSH   = 2 * r;
      localparam int TSH   = 2 * (r % QROWS);
      localparam bit UPPER = (r >= QROWS);

      logic        prevBit;
      boothDigit_t dig;
      logic [DW-1:0] mcand, mag, sgn, twinSh, pp;

      // Recoding boundary: the first upper-half row sees an implicit 0 in twin mode
      if (r == 0) begin : gFirst
        assign prevBit = 1'b0;
      end else if (r == QROWS) begin : gSplit
        assign prevBit = ctrl.twin ? 1'b0 : opB[2*r-1];
      end else begin : gInner
        assign prevBit = opB[2*r-1];
      end

      assign dig = boothEncode({opB[2*r+1], opB[2*r], prevBit});

      always_comb begin
        if (!ctrl.twin)
          mcand = {{WIDTH{opA[WIDTH-1]}}, opA};
        else if (UPPER)
          mcand = {{(DW-HALF){opA[WIDTH-1]}}, opA[WIDTH-1:HALF]};
        else
          mcand = {{(DW-HALF){opA[HALF-1]}}, opA[HALF-1:0]};

        if (dig.two)      mag = mcand << 1;
        else if (dig.one) mag = mcand;
        else              mag = '0;

        sgn    = dig.neg ? (-mag) : mag;
        twinSh = sgn << TSH;

        // Twin rows are cut at their own field: no sign extension crosses over
        if (!ctrl.twin) pp = sgn << FSH;
        else if (UPPER) pp = {twinSh[WIDTH-1:0], {WIDTH{1'b0}}};
        else            pp = {{WIDTH{1'b0}}, twinSh[WIDTH-1:0]};
      end

      assign rowPp[r] = pp;
    end
  endgenerate

  // Two field adders joined by one mode-gated carry path
  logic [WIDTH+CW-1:0] lowSum;
  logic [WIDTH-1:0]    highSum;
  logic [CW-1:0]       fieldCarry;
  logic [DW-1:0]       sumWord;

  always_comb begin
    lowSum  = '0;
    highSum = '0;
    for (int r = 0; r < ROWS; r++) begin
      lowSum  = lowSum + {{CW{1'b0}}, rowPp[r][WIDTH-1:0]};
      highSum = highSum + rowPp[r][DW-1:WIDTH];
    end
    fieldCarry = ctrl.twin ? '0 : lowSum[WIDTH+CW-1:WIDTH];
    sumWord    = {highSum + {{(WIDTH-CW){1'b0}}, fieldCarry}, lowSum[WIDTH-1:0]};
  end

  generate
    if (REG_OUT) begin : gRegOut
      logic [DW-1:0] productQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          productQ <= '0;
        else if (ctrl.load) productQ <= sumWord;
      end
      assign product = productQ;
    end else begin : gCombOut
      assign product = sumWord;
    end
  endgenerate

endmodule

// File: rtl/twin_booth_mul.sv
module twin_booth_mul
  import twin_booth_pkg::*;
#(
  parameter int WIDTH   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic               twinMode,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic               outValid,
  output logic [2*WIDTH-1:0] result
);

  mulCtrl_t ctrl;

  twin_booth_ctrl #(.REG_OUT(REG_OUT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .twinMode (twinMode),
    .ctrl     (ctrl),
    .outValid (outValid)
  );

  twin_booth_dp #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .opA     (opA),
    .opB     (opB),
    .ctrl    (ctrl),
    .product (result)
  );

endmodule

// File: rtl/twin_booth_chk.sv
module twin_booth_chk #(
  parameter int WIDTH   = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic               twinMode,
  input logic [WIDTH-1:0]   opA,
  input logic [WIDTH-1:0]   opB,
  input logic               outValid,
  input logic [2*WIDTH-1:0] result
);

  localparam int HALF = WIDTH / 2;

  logic signed [2*WIDTH-1:0] expFull;
  logic signed [WIDTH-1:0]   expLo, expHi;

  always_comb begin
    expFull = $signed({{WIDTH{opA[WIDTH-1]}}, opA}) * $signed({{WIDTH{opB[WIDTH-1]}}, opB});
    expLo   = $signed({{HALF{opA[HALF-1]}}, opA[HALF-1:0]}) *
              $signed({{HALF{opB[HALF-1]}}, opB[HALF-1:0]});
    expHi   = $signed({{HALF{opA[WIDTH-1]}}, opA[WIDTH-1:HALF]}) *
              $signed({{HALF{opB[WIDTH-1]}}, opB[WIDTH-1:HALF]});
  end

  generate
    if (REG_OUT) begin : gRegChk
      p_full_product_r1: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && !twinMode) |=> (result == $past(expFull)));
      p_twin_low_r2: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && twinMode) |=> (result[WIDTH-1:0] == $past(expLo)));
      p_twin_high_r3: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && twinMode) |=> (result[2*WIDTH-1:WIDTH] == $past(expHi)));
      p_valid_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> outValid);
      p_valid_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> !outValid);
      p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
        !inValid |=> $stable(result));
    end else begin : gCombChk
      p_full_product_r1: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && !twinMode) |-> (result == expFull));
      p_twin_low_r2: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && twinMode) |-> (result[WIDTH-1:0] == expLo));
      p_twin_high_r3: assert property (@(posedge clk) disable iff (!rstN)
        (inValid && twinMode) |-> (result[2*WIDTH-1:WIDTH] == expHi));
      p_valid_pass_r5: assert property (@(posedge clk) disable iff (!rstN)
        outValid == inValid);
    end
  endgenerate

endmodule

bind twin_booth_mul twin_booth_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .twinMode (twinMode),
  .opA      (opA),
  .opB      (opB),
  .outValid (outValid),
  .result   (result)
);

// File: tb/twin_booth_mul_bench.sv
`timescale 1ns/1ps
module twin_booth_mul_bench;

  localparam int W = 8;
  localparam int H = W / 2;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           inValid = 1'b0;
  logic           twinMode = 1'b0;
  logic [W-1:0]   opA = '0;
  logic [W-1:0]   opB = '0;
  logic           outValid;
  logic [2*W-1:0] result;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // Model of the output register and valid flag
  logic [2*W-1:0] modelQ = '0;
  logic           modelV = 1'b0;
  logic           modelTwin = 1'b0;
  logic           pend = 1'b0;
  string          pendTag = "";

  always #4 clk = ~clk;

  twin_booth_mul #(.WIDTH(W), .REG_OUT(1'b1)) u_twin_booth_mul (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .twinMode (twinMode),
    .opA      (opA),
    .opB      (opB),
    .outValid (outValid),
    .result   (result)
  );

  function automatic logic [2*W-1:0] refProd(input logic [W-1:0] a, input logic [W-1:0] b,
                                             input logic tw);
    logic signed [2*W-1:0] pf;
    logic signed [W-1:0]   pl, ph;
    pf = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
    pl = $signed({{H{a[H-1]}}, a[H-1:0]}) * $signed({{H{b[H-1]}}, b[H-1:0]});
    ph = $signed({{H{a[W-1]}}, a[W-1:H]}) * $signed({{H{b[W-1]}}, b[W-1:H]});
    return tw ? {ph, pl} : pf;
  endfunction

  task automatic check(input string tag, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkPending();
    if (modelTwin) begin
      check({pendTag, " R2 low field"},  {{W{1'b0}}, result[W-1:0]},   {{W{1'b0}}, modelQ[W-1:0]});
      check({pendTag, " R3 high field"}, {{W{1'b0}}, result[2*W-1:W]}, {{W{1'b0}}, modelQ[2*W-1:W]});
    end else begin
      check({pendTag, " R1 full"}, result, modelQ);
    end
    if (outValid !== modelV) begin
      compared++;
      mismatched++;
      $display("FAIL R5 outValid actual=%b expected=%b", outValid, modelV);
    end
  endtask

  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b, input logic tw,
                      input logic v, input string tag);
    @(negedge clk);
    if (pend) checkPending();
    opA = a; opB = b; twinMode = tw; inValid = v;
    if (v) begin
      modelQ    = refProd(a, b, tw);
      modelTwin = tw;
    end
    modelV  = v;
    pendTag = tag;
    pend    = 1'b1;
  endtask

  function automatic logic [H-1:0] corner(input int k);
    case (k)
      0:       return {1'b1, {(H-1){1'b0}}};
      1:       return {H{1'b1}};
      2:       return '0;
      default: return {1'b0, {(H-1){1'b1}}};
    endcase
  endfunction

  function automatic logic [W-1:0] cornerFull(input int k);
    case (k)
      0:       return {1'b1, {(W-1){1'b0}}};
      1:       return {W{1'b1}};
      2:       return '0;
      default: return {1'b0, {(W-1){1'b1}}};
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R7: reset state
    repeat (3) @(negedge clk);
    check("R7 reset result", result, '0);
    check("R7 reset outValid", {{(2*W-1){1'b0}}, outValid}, '0);
    rstN = 1'b1;

    // R1: exhaustive full mode
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        step(W'(a), W'(b), 1'b0, 1'b1, "sweep");

    // R2/R3: exhaustive twin mode
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 256; b++)
        step(W'(a), W'(b), 1'b1, 1'b1, "twin sweep");

    // R8: extremes in each half and in the full word
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        step({corner(i), corner(j)}, {corner(j), corner(i)}, 1'b1, 1'b1, "R8 corner twin");
        step(cornerFull(i), cornerFull(j), 1'b0, 1'b1, "R8 corner full");
      end

    // R4: lower halves fixed, upper halves swept; low field must stay put
    for (int k = 0; k < 16; k++)
      step({4'(k), 4'h7}, {4'(15 - k), 4'hD}, 1'b1, 1'b1, "R4 isolation");

    // R6: inValid low with new operands and mode must hold the result
    step(8'h5A, 8'hC3, 1'b0, 1'b1, "R6 setup");
    step(8'h81, 8'h7F, 1'b1, 1'b0, "R6 hold twin");
    step(8'hFF, 8'h80, 1'b0, 1'b0, "R6 hold full");
    step(8'h12, 8'h34, 1'b1, 1'b1, "R5 reload");

    @(negedge clk);
    if (pend) checkPending();
    pend = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule